// File: doc/BRIEF.md
# XOR Parity Stripe Engine

This block is a self-driving work element for a host-attached accelerator. Software hands it one pointer to a small job descriptor in host memory. The engine fetches that descriptor and learns four things from it: a byte count and three line-aligned buffer addresses. It then walks both source buffers one 128-byte line at a time. For each line it reads the two sources, combines them with XOR, and writes the result to the parity buffer. When the byte count is used up, it writes a non-zero completion word into host memory just past the descriptor and goes quiet.

The engine speaks four simple ports:

- A tagged command port, on which it issues reads and writes.
- A response port, on which the host reports the completion of a tag.
- An inbound transfer port, on which read data arrives as two 64-byte halves.
- An outbound fetch port, on which the host pulls write data with a latency of one clock.

Each purpose owns a fixed tag, so the host never sees two live commands with the same tag. The engine only moves while its enable input is high. A synchronous reset returns it to its idle start point.

Top module: `xor_stripe_engine`

## Requirements
- R1: After reset the command valid stays low while `en` is low. The first command after `en` rises is a one-clock descriptor read: tag 0, opcode `RD_OPC` (default 8'h0A), size 32, address `desc_ptr`.
- R2: The descriptor lies in inbound half 0, and byte b of a half is carried on bus bits [8b:8b+7], with bit 0 at the first bus position. The byte count sits at bytes 0-7, the first source pointer at bytes 8-15, the second source pointer at bytes 16-23 and the destination pointer at bytes 24-31. Each field is stored least-significant byte first and is byte-reversed before use.
- R3: For each line the engine issues a read with tag 1 at the first source pointer. On the next clock it issues a read with tag 2 at the second source pointer. Both reads use opcode `RD_OPC` and size 128. Command tags never exceed 4.
- R4: Inbound data is stored only when `bw_valid` is high and both the tag and the half address match. When the same half is delivered more than once, the last delivery is the one kept.
- R5: The parity write (tag 3, opcode `WR_OPC` default 8'h0D, size 128, destination pointer) is issued only after both source reads have answered. A fetch on the outbound port for tag 3 returns, one clock later, source1 XOR source2 for the requested half.
- R6: Each tag-3 response advances all three pointers by 128 and lowers the remaining count by 128. Lines repeat until the count reaches zero. A count of zero issues no source reads at all.
- R7: At the end the engine issues one write with tag 4, size 8 and address `desc_ptr`+32. Its fetched half 0 holds the 64-bit value 1, least-significant byte first. After that the command valid stays low until reset.
- R8: `cmd_opcode_par`, `cmd_addr_par`, `cmd_tag_par` and `br_data_par` each give odd parity over their field. `br_latency` reads 1.
- R9: A state waiting on a response moves on only for a response whose tag matches. Responses carrying other tags are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Engine advances only while high |
| desc_ptr | input | 64 | Host address of the job descriptor |
| cmd_valid | output | 1 | Command present this clock |
| cmd_opcode | output | OPW | Read or write opcode |
| cmd_opcode_par | output | 1 | Odd parity of cmd_opcode |
| cmd_tag | output | 8 | Purpose tag (0..4) |
| cmd_tag_par | output | 1 | Odd parity of cmd_tag |
| cmd_addr | output | 64 | Host byte address |
| cmd_addr_par | output | 1 | Odd parity of cmd_addr |
| cmd_size | output | 12 | Transfer size in bytes |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | 8 | Tag being completed |
| bw_valid | input | 1 | Inbound data transfer present |
| bw_tag | input | 8 | Tag of the inbound data |
| bw_half | input | 1 | Half address (0 lower 64 bytes, 1 upper) |
| bw_data | input | 512 | Inbound data, byte b at bits [8b:8b+7] |
| br_valid | input | 1 | Outbound data fetch request |
| br_tag | input | 8 | Tag being fetched |
| br_half | input | 1 | Half being fetched |
| br_data | output | 512 | Outbound data, one clock after the fetch |
| br_data_par | output | 1 | Odd parity of br_data |
| br_latency | output | 4 | Fetch latency, fixed at 1 |

## Verification
The second source read is issued in the clock right after the first, so two commands appear back to back. That pair must keep its order and its tags while the host answers the first one. The bench sweeps line counts 0 to 3 and, in half of the runs, buries each answer in noise:

- a response with a foreign tag;
- data carrying the wrong tag or the wrong half;
- a garbage copy of half 0 followed by the correct copy.

It then judges two things: the command stream against a list built from the descriptor, and the parity bytes written back against XOR values computed from the fill pattern. An early advance or a kept stale copy shows up as a wrong parity byte or a missing command.

// File: rtl/xor_stripe_engine.sv
module xor_stripe_engine #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] RD_OPC = 8'h0A,
  parameter logic [OPW-1:0] WR_OPC = 8'h0D
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [63:0]    desc_ptr,
  output logic           cmd_valid,
  output logic [OPW-1:0] cmd_opcode,
  output logic           cmd_opcode_par,
  output logic [7:0]     cmd_tag,
  output logic           cmd_tag_par,
  output logic [63:0]    cmd_addr,
  output logic           cmd_addr_par,
  output logic [11:0]    cmd_size,
  input  logic           rsp_valid,
  input  logic [7:0]     rsp_tag,
  input  logic           bw_valid,
  input  logic [7:0]     bw_tag,
  input  logic           bw_half,
  input  logic [0:511]   bw_data,
  input  logic           br_valid,
  input  logic [7:0]     br_tag,
  input  logic           br_half,
  output logic [0:511]   br_data,
  output logic           br_data_par,
  output logic [3:0]     br_latency
);
  localparam logic [63:0] LINE = 64'd128;
  localparam logic [7:0]  T_DESC = 8'd0, T_SA = 8'd1, T_SB = 8'd2, T_PAR = 8'd3, T_FIN = 8'd4;

  typedef enum logic [2:0] {S_START, S_WDESC, S_REQ, S_WSTR, S_WR, S_DONE} st_t;

  st_t          st;
  logic         step, got_a, got_b;
  logic [63:0]  rem, pa, pb, pp;
  logic [0:511] sa [0:1];
  logic [0:511] sb [0:1];

  function automatic logic [63:0] le64(input logic [0:63] f);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = f[8*i +: 8];
    return v;
  endfunction

  wire hit_a   = rsp_valid && rsp_tag == T_SA;
  wire hit_b   = rsp_valid && rsp_tag == T_SB;
  wire hit_d   = rsp_valid && rsp_tag == T_DESC;
  wire hit_p   = rsp_valid && rsp_tag == T_PAR;
  wire take_d  = bw_valid && bw_tag == T_DESC && !bw_half;

  assign cmd_opcode_par = ~^cmd_opcode;
  assign cmd_addr_par   = ~^cmd_addr;
  assign cmd_tag_par    = ~^cmd_tag;
  assign br_data_par    = ~^br_data;
  assign br_latency     = 4'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_START;
      step <= 1'b0;
      got_a <= 1'b0;
      got_b <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_opcode <= '0;
      cmd_tag <= '0;
      cmd_addr <= '0;
      cmd_size <= '0;
      rem <= '0;
      pa <= '0;
      pb <= '0;
      pp <= '0;
    end else if (en) begin
      cmd_valid <= 1'b0;
      if (take_d) begin
        rem <= le64(bw_data[0:63]);
        pa  <= le64(bw_data[64:127]);
        pb  <= le64(bw_data[128:191]);
        pp  <= le64(bw_data[192:255]);
      end
      case (st)
        S_START: begin
          cmd_valid <= 1'b1;
          cmd_opcode <= RD_OPC;
          cmd_tag <= T_DESC;
          cmd_addr <= desc_ptr;
          cmd_size <= 12'd32;
          st <= S_WDESC;
        end
        S_WDESC: if (hit_d) st <= S_REQ;
        S_REQ: begin
          if (rem == '0) begin
            st <= S_DONE;
          end else if (!step) begin
            cmd_valid <= 1'b1;
            cmd_opcode <= RD_OPC;
            cmd_tag <= T_SA;
            cmd_addr <= pa;
            cmd_size <= 12'd128;
            step <= 1'b1;
          end else begin
            cmd_valid <= 1'b1;
            cmd_opcode <= RD_OPC;
            cmd_tag <= T_SB;
            cmd_addr <= pb;
            cmd_size <= 12'd128;
            step <= 1'b0;
            got_a <= 1'b0;
            got_b <= 1'b0;
            st <= S_WSTR;
          end
        end
        S_WSTR: begin
          if (hit_a) got_a <= 1'b1;
          if (hit_b) got_b <= 1'b1;
          if ((got_a || hit_a) && (got_b || hit_b)) st <= S_WR;
        end
        S_WR: begin
          if (!step) begin
            cmd_valid <= 1'b1;
            cmd_opcode <= WR_OPC;
            cmd_tag <= T_PAR;
            cmd_addr <= pp;
            cmd_size <= 12'd128;
            step <= 1'b1;
          end else if (hit_p) begin
            step <= 1'b0;
            pa <= pa + LINE;
            pb <= pb + LINE;
            pp <= pp + LINE;
            rem <= (rem > LINE) ? rem - LINE : '0;
            st <= S_REQ;
          end
        end
        default: begin
          if (!step) begin
            cmd_valid <= 1'b1;
            cmd_opcode <= WR_OPC;
            cmd_tag <= T_FIN;
            cmd_addr <= desc_ptr + 64'd32;
            cmd_size <= 12'd8;
            step <= 1'b1;
          end
        end
      endcase
    end else begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int h = 0; h < 2; h++) begin
        sa[h] <= '0;
        sb[h] <= '0;
      end
    end else if (en && bw_valid) begin
      if (bw_tag == T_SA) sa[bw_half] <= bw_data;
      if (bw_tag == T_SB) sb[bw_half] <= bw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      br_data <= '0;
    end else if (br_valid) begin
      case (br_tag)
        T_PAR:   br_data <= sa[br_half] ^ sb[br_half];
        T_FIN:   br_data <= br_half ? '0 : {8'h01, 504'd0};
        default: br_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xor_stripe_engine_chk.sv
module xor_stripe_engine_chk #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] RD_OPC = 8'h0A,
  parameter logic [OPW-1:0] WR_OPC = 8'h0D
) (
  input logic           clk,
  input logic           rst,
  input logic [63:0]    desc_ptr,
  input logic           cmd_valid,
  input logic [OPW-1:0] cmd_opcode,
  input logic [7:0]     cmd_tag,
  input logic [63:0]    cmd_addr,
  input logic [11:0]    cmd_size
);
  logic halted;
  always_ff @(posedge clk) begin
    if (rst) halted <= 1'b0;
    else if (cmd_valid && cmd_tag == 8'd4) halted <= 1'b1;
  end

  // R1
  desc_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_tag == 8'd0 |-> cmd_opcode == RD_OPC && cmd_size == 12'd32 && cmd_addr == desc_ptr);
  // R1
  desc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_tag == 8'd0 |=> !cmd_valid);
  // R3
  pair_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_tag == 8'd1 |=> cmd_valid && cmd_tag == 8'd2);
  // R3
  tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_tag <= 8'd4);
  // R5
  par_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_tag == 8'd3 |-> cmd_opcode == WR_OPC && cmd_size == 12'd128);
  // R7
  fin_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_tag == 8'd4 |-> cmd_opcode == WR_OPC && cmd_size == 12'd8 && cmd_addr == desc_ptr + 64'd32);
  // R7
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !cmd_valid);
endmodule

bind xor_stripe_engine xor_stripe_engine_chk #(.OPW(OPW), .RD_OPC(RD_OPC), .WR_OPC(WR_OPC)) u_chk (
  .clk(clk), .rst(rst), .desc_ptr(desc_ptr), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
  .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .cmd_size(cmd_size));

// File: tb/xor_stripe_engine_test.sv
module xor_stripe_engine_test;
  localparam int CLK_P = 10;
  localparam logic [63:0] DESC = 64'h080, SA = 64'h400, SB = 64'h800, PP = 64'hC00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [63:0] desc_ptr = DESC;
  logic cmd_valid, cmd_opcode_par, cmd_tag_par, cmd_addr_par, br_data_par;
  logic [7:0] cmd_opcode, cmd_tag;
  logic [63:0] cmd_addr;
  logic [11:0] cmd_size;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_tag = '0;
  logic bw_valid = 1'b0;
  logic [7:0] bw_tag = '0;
  logic bw_half = 1'b0;
  logic [0:511] bw_data = '0;
  logic br_valid = 1'b0;
  logic [7:0] br_tag = '0;
  logic br_half = 1'b0;
  logic [0:511] br_data;
  logic [3:0] br_latency;

  xor_stripe_engine uut (
    .clk(clk), .rst(rst), .en(en), .desc_ptr(desc_ptr),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_opcode_par(cmd_opcode_par),
    .cmd_tag(cmd_tag), .cmd_tag_par(cmd_tag_par), .cmd_addr(cmd_addr), .cmd_addr_par(cmd_addr_par),
    .cmd_size(cmd_size), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .bw_valid(bw_valid), .bw_tag(bw_tag), .bw_half(bw_half), .bw_data(bw_data),
    .br_valid(br_valid), .br_tag(br_tag), .br_half(br_half), .br_data(br_data),
    .br_data_par(br_data_par), .br_latency(br_latency));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] mem [0:4095];
  logic [7:0]  e_op [0:15];
  logic [7:0]  e_tag [0:15];
  logic [63:0] e_addr [0:15];
  int          e_size [0:15];
  int e_n = 0, mon_i = 0;
  logic [7:0]  q_op [0:15];
  logic [7:0]  q_tag [0:15];
  logic [63:0] q_addr [0:15];
  int          q_size [0:15];
  int q_w = 0, q_r = 0;
  bit noisy = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j, input int i, input int s);
    return 8'((i * 7 + j * 29 + s * 101 + 3) & 255);
  endfunction

  function automatic logic [0:511] half_of(input logic [63:0] a, input int h);
    logic [0:511] r;
    for (int b = 0; b < 64; b++) r[8*b +: 8] = mem[(int'(a) + 64*h + b) & 4095];
    return r;
  endfunction

  task automatic put64(input int a, input logic [63:0] v);
    for (int b = 0; b < 8; b++) mem[a + b] = v[8*b +: 8];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && cmd_valid) begin
      check(cmd_opcode_par == ~^cmd_opcode, "R8", "opcode parity", cmd_opcode_par, ~^cmd_opcode);
      check(cmd_tag_par == ~^cmd_tag, "R8", "tag parity", cmd_tag_par, ~^cmd_tag);
      check(cmd_addr_par == ~^cmd_addr, "R8", "address parity", cmd_addr_par, ~^cmd_addr);
      if (mon_i >= e_n) begin
        check(1'b0, "R7", "command after completion, tag", cmd_tag, 0);
      end else begin
        check(cmd_tag == e_tag[mon_i], "R3", "command tag", cmd_tag, e_tag[mon_i]);
        check(cmd_opcode == e_op[mon_i], "R5", "command opcode", cmd_opcode, e_op[mon_i]);
        check(cmd_addr == e_addr[mon_i], "R6", "command address", cmd_addr, e_addr[mon_i]);
        check(int'(cmd_size) == e_size[mon_i], "R2", "command size", cmd_size, e_size[mon_i]);
      end
      mon_i++;
      q_op[q_w & 15] = cmd_opcode;
      q_tag[q_w & 15] = cmd_tag;
      q_addr[q_w & 15] = cmd_addr;
      q_size[q_w & 15] = int'(cmd_size);
      q_w++;
    end
  end

  task automatic send_half(input logic [7:0] t, input logic h, input logic [0:511] d);
    bw_valid = 1'b1; bw_tag = t; bw_half = h; bw_data = d;
    @(negedge clk);
    bw_valid = 1'b0;
  endtask

  task automatic respond(input logic [7:0] t);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = t;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic serve(input int k);
    logic [7:0] t;
    logic [63:0] a;
    int nh, nb;
    t = q_tag[k & 15];
    a = q_addr[k & 15];
    nh = (q_size[k & 15] > 64) ? 2 : 1;
    nb = (q_size[k & 15] > 64) ? 64 : q_size[k & 15];
    if (q_op[k & 15] == 8'h0A) begin
      if (noisy) begin
        respond(8'd7);
        send_half(8'd7, 1'b0, ~half_of(a, 0));
        if (nh == 2) send_half(t, 1'b1, half_of(a, 1));
        send_half(t, 1'b0, ~half_of(a, 0));
        send_half(t, 1'b0, half_of(a, 0));
        if (nh == 1) send_half(t, 1'b1, ~half_of(a, 0));
      end else begin
        send_half(t, 1'b0, half_of(a, 0));
        if (nh == 2) send_half(t, 1'b1, half_of(a, 1));
      end
      respond(t);
    end else begin
      for (int h = 0; h < nh; h++) begin
        br_valid = 1'b1; br_tag = t; br_half = h[0];
        @(negedge clk);
        br_valid = 1'b0;
        check(br_data_par == ~^br_data, "R8", "write data parity", br_data_par, ~^br_data);
        for (int b = 0; b < nb; b++) mem[(int'(a) + 64*h + b) & 4095] = br_data[8*b +: 8];
      end
      if (noisy) respond(8'd6);
      respond(t);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q_r != q_w) begin
        serve(q_r);
        q_r++;
      end
    end
  end

  task automatic run_job(input int j, input int nl, input bit nz);
    logic [63:0] dv;
    rst = 1'b1; en = 1'b0; noisy = nz;
    repeat (3) @(negedge clk);
    q_w = 0; q_r = 0; mon_i = 0;
    for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
    for (int i = 0; i < nl * 128; i++) begin
      mem[int'(SA) + i] = pat(j, i, 1);
      mem[int'(SB) + i] = pat(j, i, 2);
    end
    put64(int'(DESC), 64'(nl * 128));
    put64(int'(DESC) + 8, SA);
    put64(int'(DESC) + 16, SB);
    put64(int'(DESC) + 24, PP);
    put64(int'(DESC) + 32, 64'd0);
    e_n = 0;
    e_op[e_n] = 8'h0A; e_tag[e_n] = 8'd0; e_addr[e_n] = DESC; e_size[e_n] = 32; e_n++;
    for (int i = 0; i < nl; i++) begin
      e_op[e_n] = 8'h0A; e_tag[e_n] = 8'd1; e_addr[e_n] = SA + 64'(128*i); e_size[e_n] = 128; e_n++;
      e_op[e_n] = 8'h0A; e_tag[e_n] = 8'd2; e_addr[e_n] = SB + 64'(128*i); e_size[e_n] = 128; e_n++;
      e_op[e_n] = 8'h0D; e_tag[e_n] = 8'd3; e_addr[e_n] = PP + 64'(128*i); e_size[e_n] = 128; e_n++;
    end
    e_op[e_n] = 8'h0D; e_tag[e_n] = 8'd4; e_addr[e_n] = DESC + 64'd32; e_size[e_n] = 8; e_n++;
    rst = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(cmd_valid == 1'b0, "R1", "idle while disabled", cmd_valid, 0);
    end
    check(br_latency == 4'd1, "R8", "fetch latency", br_latency, 1);
    en = 1'b1;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (mem[int'(DESC) + 32] != 8'hEE && mem[int'(DESC) + 32] != 8'h00) break;
    end
    repeat (30) @(negedge clk);
    for (int b = 0; b < 8; b++) dv[8*b +: 8] = mem[int'(DESC) + 32 + b];
    check(dv == 64'd1, "R7", "completion word", dv, 1);
    check(mon_i == e_n, "R6", "command count", mon_i, e_n);
    for (int i = 0; i < nl * 128; i++)
      check(mem[int'(PP) + i] == (pat(j, i, 1) ^ pat(j, i, 2)), "R5", "parity byte", mem[int'(PP) + i], pat(j, i, 1) ^ pat(j, i, 2));
    check(mem[int'(PP) + nl * 128] == 8'hEE, "R6", "byte past last line untouched", mem[int'(PP) + nl * 128], 8'hEE);
    if (nz) check(mem[int'(DESC) + 32] == 8'h01, "R4", "noisy job completion byte", mem[int'(DESC) + 32], 1);
    if (nz) check(mon_i == e_n, "R9", "foreign tags ignored, command count", mon_i, e_n);
  endtask

  initial begin
    for (int j = 0; j < 8; j++) run_job(j, j % 4, j >= 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule